// File: doc/BRIEF.md
# Label-Requested Canned Message Server

This block holds a fixed store of canned text strings and sends one of them, one byte at a time, to a UART transmitter whenever a host asks for it by number. The host places a nonzero label number on the request input. The server finds where that message starts by reading a label table and sends the characters over a valid/ready byte interface. When the whole string has gone out, it pulses a completion strobe. The host then writes the request back to zero, and zero means "nothing wanted".

The message store is built when the design is elaborated. Each word is nine bits wide. The top bit flags a control token, so control codes can never be confused with text. A message is laid out as a label token, then its label number as a plain word, then a text-start token, then the characters, then an end token. The label table is also computed at elaboration. A package function scans the store once, and the hardware only sees a small lookup table.

Top module: `msg_server`

## Requirements
- R1: While reset is low and on the first cycle after it, tx_valid, busy, done and err are all 0.
- R2: A nonzero request with a table entry is taken on the first clock edge at which the server is idle and armed. From the next cycle, busy is 1 and the message characters appear on tx_data in store order, with tx_valid high only while busy.
- R3: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data does not change on the next cycle.
- R4: The end token is never sent. done is 1 for exactly one cycle, two cycles after the cycle of the last character handshake. busy is 0 while done is 1.
- R5: A message with no characters produces no tx_valid at all, and done two cycles after the request is taken.
- R6: A request value of zero starts nothing: busy and tx_valid stay 0.
- R7: A request still nonzero after done is not served again until it has been seen as zero while idle. A later nonzero value is then served.
- R8: Changes to the request while busy have no effect, including a brief return to zero. After done, a nonzero request that was written during busy is not served.
- R9: A request for a label with no table entry sets err. err stays 1 until reset. Nothing is sent, busy stays 0 and done does not pulse.
- R10: Labels come only from control-flagged label tokens (token code 0x01 with bit 8 set). Text bytes equal to 0x01 are sent as ordinary characters and create no label: label 7 sends 0x01, 0x09, 'Z', and a request for label 9 sets err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_label | input | LABEL_W (4) | Requested label number, 0 = none |
| tx_data | output | 8 | Character to transmit |
| tx_valid | output | 1 | tx_data holds a character |
| tx_ready | input | 1 | Transmitter accepts the character this cycle |
| busy | output | 1 | A message is being sent |
| done | output | 1 | One-cycle pulse when a message has completed |
| err | output | 1 | Sticky flag: a request named an unknown label |

## Verification
The embedded properties watch, on every cycle, the following:
- the hold rule on the transmit side while tx_ready is low;
- the single-cycle width of done and that busy has just ended when it pulses;
- that err never clears and that setting it brings no traffic;
- that tx_valid appears only while busy.

Some behaviours only the bench scenarios can show, because they depend on the stored text and on the host's history:
- which characters each label yields, in what order, and that the end token is dropped;
- the exact latency to done, including the empty message;
- the request re-arm rules around zero, both while busy and after done;
- that a text byte equal to the label code never becomes a label.

// File: rtl/msgsrv_pkg.sv
// Package: shared word format, store image and label-table builder.
// Assumes labels fit in MSG_LABEL_W bits and label 0 is never defined.
package msgsrv_pkg;

    localparam int MSG_ROM_DEPTH = 32;
    localparam int MSG_ADDR_W    = $clog2(MSG_ROM_DEPTH);
    localparam int MSG_LABEL_W   = 4;
    localparam int MSG_LABELS    = 1 << MSG_LABEL_W;

    // control token codes (valid only with the ctrl flag set)
    localparam logic [7:0] TOK_LABEL = 8'h01;
    localparam logic [7:0] TOK_TEXT  = 8'h02;
    localparam logic [7:0] TOK_END   = 8'h03;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] val;
    } rom_word_t;

    typedef rom_word_t [MSG_ROM_DEPTH-1:0] rom_image_t;

    typedef struct packed {
        logic                  hit;
        logic [MSG_ADDR_W-1:0] start;
    } label_entry_t;

    typedef label_entry_t [MSG_LABELS-1:0] label_map_t;

    function automatic rom_word_t tok(input logic [7:0] code);
        rom_word_t w;
        w.ctrl = 1'b1;
        w.val  = code;
        return w;
    endfunction

    function automatic rom_word_t chr(input logic [7:0] c);
        rom_word_t w;
        w.ctrl = 1'b0;
        w.val  = c;
        return w;
    endfunction

    // Canned message store; unused words are plain zero.
    function automatic rom_image_t build_image();
        rom_image_t img;
        img = '0;
        // label 1: "HI"
        img[0]  = tok(TOK_LABEL); img[1]  = chr(8'd1);  img[2]  = tok(TOK_TEXT);
        img[3]  = chr("H");       img[4]  = chr("I");   img[5]  = tok(TOK_END);
        // label 2: "ABC"
        img[6]  = tok(TOK_LABEL); img[7]  = chr(8'd2);  img[8]  = tok(TOK_TEXT);
        img[9]  = chr("A");       img[10] = chr("B");   img[11] = chr("C");
        img[12] = tok(TOK_END);
        // label 5: empty message
        img[13] = tok(TOK_LABEL); img[14] = chr(8'd5);  img[15] = tok(TOK_TEXT);
        img[16] = tok(TOK_END);
        // label 7: text containing the label code as data
        img[17] = tok(TOK_LABEL); img[18] = chr(8'd7);  img[19] = tok(TOK_TEXT);
        img[20] = chr(8'h01);     img[21] = chr(8'h09); img[22] = chr("Z");
        img[23] = tok(TOK_END);
        return img;
    endfunction

    // Elaboration-time scan: only flagged label tokens define entries.
    function automatic label_map_t build_label_map(input rom_image_t img);
        label_map_t m;
        m = '0;
        for (int i = 0; i + 3 < MSG_ROM_DEPTH; i++) begin
            if (img[i].ctrl && img[i].val == TOK_LABEL && !img[i+1].ctrl &&
                img[i+1].val != 8'd0 && int'(img[i+1].val) < MSG_LABELS &&
                img[i+2].ctrl && img[i+2].val == TOK_TEXT) begin
                m[img[i+1].val[MSG_LABEL_W-1:0]].hit   = 1'b1;
                m[img[i+1].val[MSG_LABEL_W-1:0]].start = MSG_ADDR_W'(i + 3);
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/msgsrv_rom.sv
// Message store: combinational read of the elaborated image.
// Assumes ADDR_W matches the package store depth.
module msgsrv_rom
    import msgsrv_pkg::*;
#(
    parameter int ADDR_W = MSG_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              word_ctrl,
    output logic [7:0]        word_val
);
    localparam rom_image_t IMAGE = build_image();

    // read the addressed word
    always_comb begin
        word_ctrl = IMAGE[addr].ctrl;
        word_val  = IMAGE[addr].val;
    end
endmodule

// File: rtl/msgsrv_label_table.sv
// Redirection table: label number -> first character address.
// Built from the store image at elaboration; no run-time search.
module msgsrv_label_table
    import msgsrv_pkg::*;
#(
    parameter int LABEL_W = MSG_LABEL_W,
    parameter int ADDR_W  = MSG_ADDR_W
) (
    input  logic [LABEL_W-1:0] label,
    output logic               hit,
    output logic [ADDR_W-1:0]  start
);
    localparam label_map_t MAP = build_label_map(build_image());

    // look up the entry
    always_comb begin
        hit   = MAP[label].hit;
        start = MAP[label].start;
    end
endmodule

// File: rtl/msgsrv_req_gate.sv
// Request gate: a nonzero request starts work only once per return
// to zero, and the request is only observed while the server is idle.
module msgsrv_req_gate #(
    parameter int LABEL_W = msgsrv_pkg::MSG_LABEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LABEL_W-1:0] req_label,
    input  logic               idle,
    output logic               start
);
    logic armed;

    assign start = idle && armed && (req_label != '0);

    // re-arm on zero seen while idle, disarm on a taken request
    always_ff @(posedge clk) begin
        if (!rst_n)                        armed <= 1'b1;
        else if (idle && req_label == '0)  armed <= 1'b1;
        else if (start)                    armed <= 1'b0;
    end

    // R7: after a request is taken, the same value cannot start again next cycle
    assert_no_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/msg_server.sv
// Label-requested canned message server (top).
// Takes a request, sends the message characters over valid/ready,
// pulses done; unknown labels set a sticky err. Assumes the host
// clears the request to zero after done.
module msg_server
    import msgsrv_pkg::*;
#(
    parameter int LABEL_W = MSG_LABEL_W,
    parameter int ADDR_W  = MSG_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LABEL_W-1:0] req_label,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic               busy,
    output logic               done,
    output logic               err
);
    typedef enum logic {ST_IDLE, ST_SEND} state_t;

    state_t            state;
    logic [ADDR_W-1:0] ptr;
    logic              start;
    logic              hit;
    logic [ADDR_W-1:0] first_addr;
    logic              word_ctrl;
    logic [7:0]        word_val;

    msgsrv_req_gate #(.LABEL_W(LABEL_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .req_label(req_label),
        .idle(state == ST_IDLE), .start(start)
    );

    msgsrv_label_table #(.LABEL_W(LABEL_W), .ADDR_W(ADDR_W)) u_table (
        .label(req_label), .hit(hit), .start(first_addr)
    );

    msgsrv_rom #(.ADDR_W(ADDR_W)) u_rom (
        .addr(ptr), .word_ctrl(word_ctrl), .word_val(word_val)
    );

    // present the current character; control words are never sent
    always_comb begin
        tx_valid = (state == ST_SEND) && !word_ctrl;
        tx_data  = word_val;
        busy     = (state == ST_SEND);
    end

    // sequencer: start, advance on handshake, finish on end token
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ptr   <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (hit) begin
                            state <= ST_SEND;
                            ptr   <= first_addr;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (word_ctrl) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (tx_ready) begin
                        ptr <= ptr + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_hold_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !tx_valid));
    assert_valid_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);
endmodule

// File: tb/tb_msg_server.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed corner tests.
module tb_msg_server;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_label = '0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b1;
    logic       busy, done, err;

    int checks = 0;
    int errors = 0;

    logic [7:0] got [4];
    int         got_n;
    bit         got_done;

    always #2.5 clk = ~clk;

    msg_server dut (
        .clk(clk), .rst_n(rst_n), .req_label(req_label),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .busy(busy), .done(done), .err(err)
    );

    // {label, length, byte0, byte1, byte2, stall}
    localparam logic [31:0] VEC [5] = '{
        {4'd1, 3'd2, 8'h48, 8'h49, 8'h00, 1'b0},
        {4'd2, 3'd3, 8'h41, 8'h42, 8'h43, 1'b1},
        {4'd5, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0},
        {4'd7, 3'd3, 8'h01, 8'h09, 8'h5A, 1'b1},
        {4'd1, 3'd2, 8'h48, 8'h49, 8'h00, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_label = '0;
        tx_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(!tx_valid && !busy && !done && !err, "R1 outputs in reset",
              {tx_valid, busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!tx_valid && !busy && !done && !err, "R1 outputs after reset",
              {tx_valid, busy, done, err}, 0);
    endtask

    // Request a label and collect characters until done.
    task automatic run_msg(input logic [3:0] lbl, input bit stall, input bit meddle);
        int  since = 0;
        bit  stuck = 0;
        logic [7:0] prev_d = '0;
        got_n = 0;
        got_done = 0;
        @(negedge clk);
        req_label = lbl;
        for (int cyc = 0; cyc < 200; cyc++) begin
            @(negedge clk);
            tx_ready = stall ? (cyc % 3 == 2) : 1'b1;
            if (meddle && cyc == 1) req_label = 4'd0;
            if (meddle && cyc == 2) req_label = 4'd1;
            #1;
            if (cyc == 0) check(busy, "R2 busy after request", busy, 1);
            if (stuck) check(tx_valid && tx_data == prev_d, "R3 hold while stalled",
                             tx_data, prev_d);
            since++;
            if (tx_valid && tx_ready) begin
                if (got_n < 4) got[got_n] = tx_data;
                got_n++;
                since = 0;
            end
            stuck  = tx_valid && !tx_ready;
            prev_d = tx_data;
            if (done) begin
                check(since == 2, "R4 done latency", since, 2);
                check(!busy && !tx_valid, "R4 idle at done", {busy, tx_valid}, 0);
                got_done = 1;
                break;
            end
        end
        tx_ready = 1'b1;
        @(negedge clk);
        #1;
        check(!done, "R4 done one cycle", done, 0);
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            if (busy || tx_valid || done) seen = 1;
        end
        check(!seen, tag, seen, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R6: zero request starts nothing
        quiet(8, "R6 zero request idle");

        // vector walk: R2, R3, R4, R5, R10 contents
        foreach (VEC[v]) begin
            logic [3:0] lbl;
            int         len;
            logic [7:0] exp_b [3];
            lbl = VEC[v][31:28];
            len = int'(VEC[v][27:25]);
            exp_b[0] = VEC[v][24:17];
            exp_b[1] = VEC[v][16:9];
            exp_b[2] = VEC[v][8:1];
            run_msg(lbl, VEC[v][0], 1'b0);
            check(got_done, "R4 done seen", got_done, 1);
            check(got_n == len, (len == 0) ? "R5 empty count" : "R2 char count", got_n, len);
            for (int k = 0; k < len && k < got_n; k++)
                check(got[k] == exp_b[k], (lbl == 4'd7) ? "R10 data byte" : "R2 data byte",
                      got[k], exp_b[k]);
            @(negedge clk);
            req_label = '0;
            repeat (2) @(negedge clk);
        end

        // R7: held request not repeated; served again after zero
        run_msg(4'd2, 1'b0, 1'b0);
        quiet(10, "R7 held request not repeated");
        req_label = '0;
        @(negedge clk);
        run_msg(4'd2, 1'b0, 1'b0);
        check(got_done && got_n == 3, "R7 served after zero", got_n, 3);
        req_label = '0;
        repeat (2) @(negedge clk);

        // R8: changes while busy ignored, including a brief zero
        run_msg(4'd2, 1'b1, 1'b1);
        check(got_n == 3 && got[0] == 8'h41 && got[2] == 8'h43,
              "R8 message unaffected", got_n, 3);
        quiet(10, "R8 busy-time request ignored");
        req_label = '0;
        repeat (2) @(negedge clk);

        // R9: unknown label, sticky err, silent
        @(negedge clk);
        req_label = 4'd3;
        @(negedge clk);
        #1;
        check(err, "R9 err set", err, 1);
        check(!busy && !tx_valid, "R9 nothing sent", {busy, tx_valid}, 0);
        quiet(5, "R9 no done");
        req_label = '0;
        @(negedge clk);
        run_msg(4'd1, 1'b0, 1'b0);
        check(err && got_n == 2, "R9 err sticky", err, 1);
        req_label = '0;

        // R10: data byte 0x09 after 0x01 defines no label 9
        do_reset();
        @(negedge clk);
        req_label = 4'd9;
        @(negedge clk);
        #1;
        check(err && !busy, "R10 label 9 undefined", err, 1);
        req_label = '0;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule